// File: doc/BRIEF.md
# Multi-Line Reservation Monitor

This block keeps track of the atomic reservations held by one hardware thread. A load-reserve request that carries a physical address opens a reservation on the 64-byte cache line that holds that address. Up to eight lines can be reserved at once, and each reservation sits in its own slot. While a sequence is open, the block watches exclusive snoops from other agents. It decides each conflict by thread priority. The losing side is either the remote agent, which gets a retry pulse, or the local sequence, which becomes doomed.

The cache is modelled only as a grant/deny bit. For a load-reserve this bit reports whether the line was obtained exclusive. A denied fetch does not stall the load-reserve and does not signal anything at that point. The failure appears only when the sequence closes. A store-conditional/commit request closes the sequence. The block answers one cycle later with a done pulse and a success bit. On failure it also gives a recovery selector: either restart the sequence from its first instruction, or branch to a fixed handler. The choice depends on whether the first failure came before or after the sequence passed its interference check point.

Top module: `rsv_monitor`

## Requirements
- R1: Up to 8 reservations can be open at once, each on a distinct line. A load-reserve whose line (address bits [PA_W-1:6]) is already reserved reuses that slot and takes no new one.
- R2: Conflicts are found at line granularity. Two addresses that differ only in bits [5:0] are the same line, both for load-reserve reuse and for snoop hits.
- R3: A load-reserve with `lr_excl_ok`=0 produces no output of its own. The line is doomed, and the next commit reports failure.
- R4: An exclusive snoop (`snp_excl`=1) that hits a reserved line with `snp_prio` >= `local_prio` makes the sequence fail. Equal priority counts as a remote win. No `snp_nack` is raised.
- R5: An exclusive snoop that hits a reserved line with `snp_prio` < `local_prio` raises `snp_nack` for one cycle, in the cycle after the snoop. The reservation stays intact.
- R6: A non-exclusive snoop, or a snoop to a line that is not reserved, has no effect on the sequence and raises no `snp_nack`.
- R7: A load-reserve to a new line while all 8 slots are full makes the sequence fail.
- R8: `sc_valid` produces a one-cycle `sc_done` in the next cycle. `sc_success`=1 only if at least one slot is open, no slot is doomed or interfered, and no overflow occurred. Every slot and every failure record is then cleared.
- R9: On failure, `fail_mode`=0 (restart) if the first failure event came before any `chk_valid` pulse in the sequence, or if there was no failure event at all (empty sequence). `fail_mode`=1 (handler) if the first failure came after the check point. `fail_mode` is 0 whenever `sc_success`=1.
- R10: A load-reserve, snoop or check pulse presented in the same cycle as `sc_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_prio | input | PRIO_W | Priority of the local thread |
| lr_valid | input | 1 | Load-reserve request |
| lr_addr | input | PA_W | Physical address of the load-reserve |
| lr_excl_ok | input | 1 | Line obtained exclusive (1) or exclusive denied (0) |
| chk_valid | input | 1 | Sequence passed its interference check point |
| snp_valid | input | 1 | Snoop or remote request present |
| snp_addr | input | PA_W | Physical address of the snoop |
| snp_prio | input | PRIO_W | Priority of the remote requester |
| snp_excl | input | 1 | Snoop requests the line exclusive |
| sc_valid | input | 1 | Store-conditional / commit request |
| sc_done | output | 1 | Commit result valid (one-cycle pulse) |
| sc_success | output | 1 | Commit succeeded |
| fail_mode | output | 1 | Recovery target: 0 restart, 1 handler |
| snp_nack | output | 1 | Remote exclusive request refused by priority |

## Verification
Every result is registered exactly once. The commit answer (`sc_done`, `sc_success`, `fail_mode`) appears in the cycle after `sc_valid`. The refusal `snp_nack` appears in the cycle after the snoop that caused it. The bench drives one cycle of inputs, waits for the rising edge, samples one time unit later, and compares all four outputs with a model that it updates from the same inputs. Each output is therefore judged exactly one edge after its cause. Directed sequences cover full, overflow, denied-fetch, equal-priority, refusal and same-cycle-commit cases. Random cycles over a small pool of lines then mix load-reserves, snoops, check pulses and commits.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef struct packed {
        logic failed;
        logic phase;
        logic past_chk;
        logic ovf;
        logic sc_done;
        logic sc_success;
        logic fail_mode;
        logic snp_nack;
    } mon_state_t;

endpackage

// File: rtl/rsv_alloc.sv
module rsv_alloc #(
    parameter int N = 8
) (
    input  logic [N-1:0] free_vec,
    output logic [N-1:0] pick_oh,
    output logic         any_free
);
    always_comb begin
        logic found;
        found   = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < N; i++) begin
            if (free_vec[i] && !found) begin
                pick_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
        any_free = found;
    end
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              alloc_en,
    input  logic              lr_go,
    input  logic              lr_deny,
    input  logic [LINE_W-1:0] lr_line,
    input  logic              snp_kill,
    input  logic [LINE_W-1:0] snp_line,
    output logic              valid,
    output logic              bad,
    output logic              lr_hit,
    output logic              snp_hit
);
    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] tag;
        logic              doomed;
        logic              interfered;
    } slot_t;

    slot_t slot_d, slot_q;

    assign lr_hit  = slot_q.valid && (slot_q.tag == lr_line);
    assign snp_hit = slot_q.valid && (slot_q.tag == snp_line);
    assign valid   = slot_q.valid;
    assign bad     = slot_q.valid && (slot_q.doomed || slot_q.interfered);

    always_comb begin
        slot_d = slot_q;
        if (clear) begin
            slot_d = '0;
        end else if (alloc_en) begin
            slot_d.valid      = 1'b1;
            slot_d.tag        = lr_line;
            slot_d.doomed     = lr_deny;
            slot_d.interfered = 1'b0;
        end else begin
            if (lr_go && lr_hit && lr_deny) slot_d.doomed = 1'b1;
            if (snp_kill && snp_hit)        slot_d.interfered = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !slot_q.valid);

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !slot_q.valid);
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int PA_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int SLOTS      = 8,
    parameter int PRIO_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] local_prio,
    input  logic              lr_valid,
    input  logic [PA_W-1:0]   lr_addr,
    input  logic              lr_excl_ok,
    input  logic              chk_valid,
    input  logic              snp_valid,
    input  logic [PA_W-1:0]   snp_addr,
    input  logic [PRIO_W-1:0] snp_prio,
    input  logic              snp_excl,
    input  logic              sc_valid,
    output logic              sc_done,
    output logic              sc_success,
    output logic              fail_mode,
    output logic              snp_nack
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = PA_W - OFS_W;

    logic [LINE_W-1:0] lr_line, snp_line;
    logic [SLOTS-1:0]  v_vec, bad_vec, lr_hit, snp_hit, pick_oh, alloc_en;
    logic              any_free, lr_go, snp_go, remote_wins;
    logic              lr_hit_any, snp_hit_any, ovf_ev, fail_ev;
    mon_state_t        st_d, st_q;

    assign lr_line     = lr_addr[PA_W-1:OFS_W];
    assign snp_line    = snp_addr[PA_W-1:OFS_W];
    assign lr_go       = lr_valid && !sc_valid;
    assign snp_go      = snp_valid && snp_excl && !sc_valid;
    assign remote_wins = (snp_prio >= local_prio);
    assign lr_hit_any  = |lr_hit;
    assign snp_hit_any = |snp_hit;
    assign alloc_en    = pick_oh & {SLOTS{lr_go && !lr_hit_any}};
    assign ovf_ev      = lr_go && !lr_hit_any && !any_free;
    assign fail_ev     = ovf_ev || (lr_go && !lr_excl_ok)
                      || (snp_go && remote_wins && snp_hit_any);

    rsv_alloc #(.N(SLOTS)) alloc_i (
        .free_vec (~v_vec),
        .pick_oh  (pick_oh),
        .any_free (any_free)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        rsv_entry #(.LINE_W(LINE_W)) entry_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (sc_valid),
            .alloc_en (alloc_en[g]),
            .lr_go    (lr_go),
            .lr_deny  (!lr_excl_ok),
            .lr_line  (lr_line),
            .snp_kill (snp_go && remote_wins),
            .snp_line (snp_line),
            .valid    (v_vec[g]),
            .bad      (bad_vec[g]),
            .lr_hit   (lr_hit[g]),
            .snp_hit  (snp_hit[g])
        );
    end

    always_comb begin
        st_d            = st_q;
        st_d.sc_done    = sc_valid;
        st_d.sc_success = 1'b0;
        st_d.fail_mode  = 1'b0;
        st_d.snp_nack   = snp_go && !remote_wins && snp_hit_any;
        if (sc_valid) begin
            st_d.sc_success = (|v_vec) && !st_q.ovf && !(|bad_vec);
            st_d.fail_mode  = !st_d.sc_success && st_q.failed && st_q.phase;
            st_d.failed     = 1'b0;
            st_d.phase      = 1'b0;
            st_d.past_chk   = 1'b0;
            st_d.ovf        = 1'b0;
        end else begin
            if (chk_valid) st_d.past_chk = 1'b1;
            if (ovf_ev)    st_d.ovf = 1'b1;
            if (fail_ev && !st_q.failed) begin
                st_d.failed = 1'b1;
                st_d.phase  = st_q.past_chk;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sc_done    = st_q.sc_done;
    assign sc_success = st_q.sc_success;
    assign fail_mode  = st_q.fail_mode;
    assign snp_nack   = st_q.snp_nack;

    assert_distinct_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lr_hit));

    assert_done_follows_sc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_done);

    assert_success_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_success |-> sc_done);

    assert_mode_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_mode |-> (sc_done && !sc_success));

    assert_nack_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_nack |-> $past(snp_valid && snp_excl && !sc_valid));

    assert_overflow_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && st_q.ovf) |=> !sc_success);
endmodule

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb_top;
    localparam int PA_W   = 32;
    localparam int OFS_W  = 6;
    localparam int LW     = PA_W - OFS_W;
    localparam int PRIO_W = 3;
    localparam int NS     = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [PRIO_W-1:0] local_prio;
    logic              lr_valid, lr_excl_ok, chk_valid, snp_valid, snp_excl, sc_valid;
    logic [PA_W-1:0]   lr_addr, snp_addr;
    logic [PRIO_W-1:0] snp_prio;
    logic              sc_done, sc_success, fail_mode, snp_nack;

    rsv_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .local_prio(local_prio),
        .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_excl_ok(lr_excl_ok),
        .chk_valid(chk_valid), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_prio(snp_prio), .snp_excl(snp_excl), .sc_valid(sc_valid),
        .sc_done(sc_done), .sc_success(sc_success), .fail_mode(fail_mode),
        .snp_nack(snp_nack)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit          m_v[NS];
    logic [LW-1:0] m_l[NS];
    bit          m_bad[NS];
    bit          m_ovf, m_failed, m_phase, m_chk;
    bit          got_done, got_succ, got_mode, got_nack;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find_line(input logic [LW-1:0] ln);
        for (int i = 0; i < NS; i++) if (m_v[i] && m_l[i] == ln) return i;
        return -1;
    endfunction

    function automatic int find_free();
        for (int i = 0; i < NS; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic clear_inputs();
        lr_valid = 0; lr_excl_ok = 1; chk_valid = 0; snp_valid = 0;
        snp_excl = 0; sc_valid = 0; lr_addr = '0; snp_addr = '0; snp_prio = '0;
    endtask

    task automatic model_clear();
        for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_bad[i] = 0; m_l[i] = '0; end
        m_ovf = 0; m_failed = 0; m_phase = 0; m_chk = 0;
    endtask

    // applies the current inputs for one clock and checks against the model
    task automatic step();
        bit e_succ, e_mode, e_nack, fe, any_v, any_bad;
        int h;
        e_succ = 0; e_mode = 0; e_nack = 0; fe = 0;
        if (sc_valid) begin
            any_v = 0; any_bad = 0;
            for (int i = 0; i < NS; i++) begin
                any_v |= m_v[i];
                any_bad |= m_v[i] & m_bad[i];
            end
            e_succ = any_v && !m_ovf && !any_bad;
            e_mode = !e_succ && m_failed && m_phase;
            model_clear();
        end else begin
            if (snp_valid && snp_excl) begin
                h = find_line(snp_addr[PA_W-1:OFS_W]);
                if (h >= 0) begin
                    if (snp_prio >= local_prio) begin m_bad[h] = 1; fe = 1; end
                    else e_nack = 1;
                end
            end
            if (lr_valid) begin
                h = find_line(lr_addr[PA_W-1:OFS_W]);
                if (h >= 0) begin
                    if (!lr_excl_ok) begin m_bad[h] = 1; fe = 1; end
                end else begin
                    h = find_free();
                    if (h >= 0) begin
                        m_v[h] = 1; m_l[h] = lr_addr[PA_W-1:OFS_W];
                        m_bad[h] = !lr_excl_ok;
                        if (!lr_excl_ok) fe = 1;
                    end else begin
                        m_ovf = 1; fe = 1;
                    end
                end
            end
            if (fe && !m_failed) begin m_failed = 1; m_phase = m_chk; end
            if (chk_valid) m_chk = 1;
        end
        @(posedge clk);
        #1;
        got_done = sc_done; got_succ = sc_success; got_mode = fail_mode; got_nack = snp_nack;
        chk(got_done == sc_valid, "R8 sc_done", got_done, sc_valid);
        chk(got_succ == e_succ, "R8 sc_success", got_succ, e_succ);
        chk(got_mode == e_mode, "R9 fail_mode", got_mode, e_mode);
        chk(got_nack == e_nack, "R5/R6 snp_nack", got_nack, e_nack);
        clear_inputs();
    endtask

    function automatic logic [PA_W-1:0] mk_addr(input int line, input int ofs);
        logic [LW-1:0] ln;
        ln = LW'(line);
        return {ln, 6'(ofs)};
    endfunction

    task automatic do_lr(input int line, input int ofs, input bit ok);
        lr_valid = 1; lr_addr = mk_addr(line, ofs); lr_excl_ok = ok; step();
    endtask

    task automatic do_snp(input int line, input int ofs, input int prio, input bit ex);
        snp_valid = 1; snp_addr = mk_addr(line, ofs); snp_prio = PRIO_W'(prio);
        snp_excl = ex; step();
    endtask

    task automatic do_chk();
        chk_valid = 1; step();
    endtask

    task automatic do_sc(input bit exp_s, input bit exp_m, input string req);
        sc_valid = 1; step();
        chk(got_succ == exp_s, req, got_succ, exp_s);
        chk(got_mode == exp_m, req, got_mode, exp_m);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        model_clear();
        local_prio = 3'd4;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk({sc_done, sc_success, fail_mode, snp_nack} == 4'b0, "R8 reset outputs",
            {sc_done, sc_success, fail_mode, snp_nack}, 0);
        rst_n = 1;

        // R1, R2: eight lines, then reuse of line 0 at another offset
        for (int i = 0; i < 8; i++) do_lr(10 + i, i, 1);
        do_lr(10, 40, 1);
        do_sc(1, 0, "R1 eight lines plus reuse");
        // R8: state cleared, empty commit fails with restart
        do_sc(0, 0, "R8 cleared after commit");

        // R7: ninth distinct line
        for (int i = 0; i < 9; i++) do_lr(30 + i, 0, 1);
        do_chk();
        do_sc(0, 0, "R7 overflow fails before check");

        // R3 and R9: denied fetch before check point -> restart
        do_lr(50, 0, 0);
        chk(sc_done == 0, "R3 silent lr", sc_done, 0);
        do_chk();
        do_sc(0, 0, "R3 doomed line restart");

        // R9: interference after check point -> handler
        do_lr(51, 8, 1);
        do_chk();
        do_snp(51, 60, 5, 1);
        do_sc(0, 1, "R9 late failure handler");

        // R4, R2: equal priority, other offset, remote wins
        do_lr(52, 0, 1);
        do_snp(52, 33, 4, 1);
        chk(got_nack == 0, "R4 no nack on remote win", got_nack, 0);
        do_sc(0, 0, "R4 equal priority fails");

        // R5: lower remote priority is refused
        do_lr(53, 0, 1);
        do_snp(53, 4, 2, 1);
        chk(got_nack == 1, "R5 nack", got_nack, 1);
        do_sc(1, 0, "R5 reservation kept");

        // R6: shared snoop and unrelated line are harmless
        do_lr(54, 0, 1);
        do_snp(54, 0, 7, 0);
        chk(got_nack == 0, "R6 shared snoop", got_nack, 0);
        do_snp(99, 0, 7, 1);
        chk(got_nack == 0, "R6 other line", got_nack, 0);
        do_sc(1, 0, "R6 sequence intact");

        // R10: lr in the commit cycle is ignored
        do_lr(55, 0, 1);
        lr_valid = 1; lr_addr = mk_addr(56, 0); lr_excl_ok = 1; sc_valid = 1; step();
        chk(got_succ == 1, "R10 commit with lr", got_succ, 1);
        do_sc(0, 0, "R10 ignored lr opened nothing");

        // random mix
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                lr_valid = 1;
                lr_addr = mk_addr(100 + $urandom_range(0, 10), $urandom_range(0, 63));
                lr_excl_ok = ($urandom_range(0, 7) != 0);
            end
            if ($urandom_range(0, 3) == 0) begin
                snp_valid = 1;
                snp_addr = mk_addr(100 + $urandom_range(0, 14), $urandom_range(0, 63));
                snp_prio = PRIO_W'($urandom_range(0, 7));
                snp_excl = $urandom_range(0, 1) != 0;
            end
            if ($urandom_range(0, 9) == 0) chk_valid = 1;
            if ($urandom_range(0, 11) == 0) sc_valid = 1;
            step();
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule